// File: doc/BRIEF.md
# Dual Pointer Circular Address Updater

This block keeps two 16-bit data pointers for a processor's data-memory path. Each pointer can be loaded, stepped by an explicit increment command, or stepped by an automatic update whose direction comes from a per-pointer direction bit. A pointer can be placed, on its own, in a circular mode. In that mode it wraps inside one of two equal-sized buffers in the low external data space. A single 8-bit length value sets the last offset of both buffers. Buffer A starts at 0x0000 and buffer B starts at 0x0100.

Which buffer applies is taken from the pointer's current value alone, so either pointer can walk either buffer. Outside the two buffers a pointer counts linearly, even with circular mode on, so it stays usable as an ordinary address pointer. The enable bits, the direction bits and the length value are held in registers inside the block. A write to them takes effect on the cycle after the write.

Top module: `cbuf_ptr_pair`

## Requirements
- R1: After reset, both pointers read 0x0000, both circular enables and both direction bits are 0, and the length register is 0x00.
- R2: A load (load_i=1) writes load_data_i into the pointer chosen by ptr_sel_i (0 = pointer 0, 1 = pointer 1) on the next clock edge. It overrides an increment or update in the same cycle and leaves the other pointer unchanged.
- R3: The explicit increment (inc_i=1) always adds one to the selected pointer, whatever its direction bit holds. It takes precedence over upd_i in the same cycle.
- R4: The automatic update (upd_i=1) increments the selected pointer when its direction bit is 0 and decrements it when the bit is 1.
- R5: With a pointer's circular enable at 0, every step is modulo 2^16: 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.
- R6: With circular mode on, incrementing a pointer equal to L (the length value) gives 0x0000, and incrementing one equal to 0x0100+L gives 0x0100.
- R7: With circular mode on, decrementing a pointer at 0x0000 gives L, and decrementing one at 0x0100 gives 0x0100+L.
- R8: With circular mode on, a pointer at any address other than the four boundary cases of R6 and R7 steps linearly. This includes addresses from L+1 to 0x00FF and addresses above 0x0100+L.
- R9: With L = 0x00, a circular increment or decrement at 0x0000 or at 0x0100 leaves the pointer unchanged.
- R10: Each pointer's circular mode and direction depend only on its own enable and direction bits. Either pointer can wrap in either buffer.
- R11: cfg_we_i=1 writes cfg_circ_i and cfg_dir_i (bit k belongs to pointer k), and len_we_i=1 writes len_i. The new values first govern a step on the following cycle; a step in the same cycle as the write uses the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Write strobe for enable and direction bits |
| cfg_circ_i | input | 2 | Circular enable per pointer (bit k = pointer k) |
| cfg_dir_i | input | 2 | Update direction per pointer, 0 up, 1 down |
| len_we_i | input | 1 | Write strobe for the length register |
| len_i | input | 8 | New length (last offset of both buffers) |
| ptr_sel_i | input | 1 | Pointer addressed by load, increment and update |
| load_i | input | 1 | Load strobe |
| load_data_i | input | 16 | Value to load |
| inc_i | input | 1 | Explicit increment strobe |
| upd_i | input | 1 | Automatic update strobe |
| ptr0_o | output | 16 | Pointer 0 value |
| ptr1_o | output | 16 | Pointer 1 value |

## Verification
The hardest case to reach is a pointer standing exactly on a buffer boundary while the length register, the enable bit and the direction bit all hold the right values. A plain walk from reset would need up to hundreds of steps to get there. The bench instead writes the configuration, loads the pointer straight onto the boundary and then issues a single step. It also writes a new length in the same cycle as a step at the old boundary, to show that the step still follows the old length.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    // Direction of an automatic update
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } step_dir_e;

endpackage

// File: rtl/cbuf_cfg.sv
module cbuf_cfg #(
    parameter int NUM_PTR = 2,
    parameter int LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [NUM_PTR-1:0] circ_in,
    input  logic [NUM_PTR-1:0] dir_in,
    input  logic               len_we,
    input  logic [LEN_W-1:0]   len_in,
    output logic [NUM_PTR-1:0] circ_o,
    output logic [NUM_PTR-1:0] dir_o,
    output logic [LEN_W-1:0]   len_o
);

    typedef struct packed {
        logic [NUM_PTR-1:0] circ;
        logic [NUM_PTR-1:0] dir;
        logic [LEN_W-1:0]   len;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            s_d.circ = circ_in;
            s_d.dir  = dir_in;
        end
        if (len_we) begin
            s_d.len = len_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign circ_o = s_q.circ;
    assign dir_o  = s_q.dir;
    assign len_o  = s_q.len;

    // R11
    len_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_we |=> (len_o == $past(len_in)));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(circ_o) && $stable(dir_o)));

endmodule

// File: rtl/cbuf_step.sv
module cbuf_step #(
    parameter int PTR_W = 16,
    parameter int LEN_W = 8
) (
    input  logic [PTR_W-1:0] cur,
    input  logic [LEN_W-1:0] len,
    input  logic             circ,
    input  logic             down,
    output logic [PTR_W-1:0] nxt
);

    localparam logic [PTR_W-1:0] BASE_B = PTR_W'(1) << LEN_W;

    logic [PTR_W-1:0] end_a;
    logic [PTR_W-1:0] end_b;

    assign end_a = PTR_W'(len);
    assign end_b = BASE_B | PTR_W'(len);

    always_comb begin
        if (circ && !down && cur == end_a) begin
            nxt = '0;
        end else if (circ && !down && cur == end_b) begin
            nxt = BASE_B;
        end else if (circ && down && cur == '0) begin
            nxt = end_a;
        end else if (circ && down && cur == BASE_B) begin
            nxt = end_b;
        end else if (down) begin
            nxt = cur - 1'b1;
        end else begin
            nxt = cur + 1'b1;
        end
    end

endmodule

// File: rtl/cbuf_slot.sv
module cbuf_slot #(
    parameter int PTR_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_data,
    input  logic             step_en,
    input  logic             step_down,
    input  logic             circ,
    input  logic [LEN_W-1:0] len,
    output logic [PTR_W-1:0] ptr_o
);

    localparam logic [PTR_W-1:0] BASE_B = PTR_W'(1) << LEN_W;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } slot_state_t;

    slot_state_t      s_d, s_q;
    logic [PTR_W-1:0] step_nxt;

    cbuf_step #(
        .PTR_W(PTR_W),
        .LEN_W(LEN_W)
    ) i_step (
        .cur (s_q.ptr),
        .len (len),
        .circ(circ),
        .down(step_down),
        .nxt (step_nxt)
    );

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.ptr = load_data;
        end else if (step_en) begin
            s_d.ptr = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_o = s_q.ptr;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr_o == $past(load_data)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(ptr_o));

    // R5
    linear_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && !step_down && !circ) |=> (ptr_o == $past(ptr_o) + 1'b1));

    // R6
    wrap_a_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && !step_down && circ && ptr_o == PTR_W'(len)) |=> (ptr_o == '0));

    // R7
    wrap_b_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && step_down && circ && ptr_o == BASE_B)
        |=> (ptr_o == (BASE_B | PTR_W'($past(len)))));

endmodule

// File: rtl/cbuf_ptr_pair.sv
module cbuf_ptr_pair #(
    parameter int PTR_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_circ_i,
    input  logic [1:0]       cfg_dir_i,
    input  logic             len_we_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             ptr_sel_i,
    input  logic             load_i,
    input  logic [PTR_W-1:0] load_data_i,
    input  logic             inc_i,
    input  logic             upd_i,
    output logic [PTR_W-1:0] ptr0_o,
    output logic [PTR_W-1:0] ptr1_o
);

    import cbuf_pkg::*;

    localparam int NUM_PTR = 2;

    logic [NUM_PTR-1:0] circ_q;
    logic [NUM_PTR-1:0] dir_q;
    logic [LEN_W-1:0]   len_q;
    logic [PTR_W-1:0]   ptr_vals [NUM_PTR];

    cbuf_cfg #(
        .NUM_PTR(NUM_PTR),
        .LEN_W  (LEN_W)
    ) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_we (cfg_we_i),
        .circ_in(cfg_circ_i),
        .dir_in (cfg_dir_i),
        .len_we (len_we_i),
        .len_in (len_i),
        .circ_o (circ_q),
        .dir_o  (dir_q),
        .len_o  (len_q)
    );

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_slot
        logic hit;
        logic ld_k;
        logic inc_k;
        logic upd_k;
        logic down_k;

        assign hit    = (ptr_sel_i == 1'(k));
        assign ld_k   = load_i && hit;
        assign inc_k  = inc_i && hit;
        assign upd_k  = upd_i && hit;
        // explicit increment ignores the direction bit
        assign down_k = !inc_k && upd_k && (step_dir_e'(dir_q[k]) == DIR_DOWN);

        cbuf_slot #(
            .PTR_W(PTR_W),
            .LEN_W(LEN_W)
        ) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld_k),
            .load_data(load_data_i),
            .step_en  (inc_k || upd_k),
            .step_down(down_k),
            .circ     (circ_q[k]),
            .len      (len_q),
            .ptr_o    (ptr_vals[k])
        );
    end

    assign ptr0_o = ptr_vals[0];
    assign ptr1_o = ptr_vals[1];

    // R3
    inc_ignores_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && !ptr_sel_i && !circ_q[0]) |=> (ptr0_o == $past(ptr0_o) + 1'b1));

    // R2
    other_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_sel_i |=> $stable(ptr0_o));

endmodule

// File: tb/test_cbuf_ptr_pair.sv
module test_cbuf_ptr_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_circ_i = '0;
    logic [1:0]  cfg_dir_i = '0;
    logic        len_we_i = 1'b0;
    logic [7:0]  len_i = '0;
    logic        ptr_sel_i = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] load_data_i = '0;
    logic        inc_i = 1'b0;
    logic        upd_i = 1'b0;
    logic [15:0] ptr0_o;
    logic [15:0] ptr1_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cbuf_ptr_pair i_cbuf_ptr_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_circ_i (cfg_circ_i),
        .cfg_dir_i  (cfg_dir_i),
        .len_we_i   (len_we_i),
        .len_i      (len_i),
        .ptr_sel_i  (ptr_sel_i),
        .load_i     (load_i),
        .load_data_i(load_data_i),
        .inc_i      (inc_i),
        .upd_i      (upd_i),
        .ptr0_o     (ptr0_o),
        .ptr1_o     (ptr1_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    // one clock with the given strobes, inputs cleared 2 ns after the edge
    task automatic pulse(input logic sel, input logic ld, input logic [15:0] data,
                         input logic inc, input logic upd);
        ptr_sel_i   = sel;
        load_i      = ld;
        load_data_i = data;
        inc_i       = inc;
        upd_i       = upd;
        @(posedge clk);
        #2;
        load_i = 1'b0;
        inc_i  = 1'b0;
        upd_i  = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] circ, input logic [1:0] dir);
        cfg_we_i   = 1'b1;
        cfg_circ_i = circ;
        cfg_dir_i  = dir;
        @(posedge clk);
        #2;
        cfg_we_i = 1'b0;
    endtask

    task automatic set_len(input logic [7:0] len);
        len_we_i = 1'b1;
        len_i    = len;
        @(posedge clk);
        #2;
        len_we_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ptr0 after reset", ptr0_o, 16'h0000);
        check("R1 ptr1 after reset", ptr1_o, 16'h0000);
        // dir bit 0 and circ off: update steps up linearly
        pulse(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R1 dir reset is up", ptr0_o, 16'h0001);
        // len 0: circular increment at 0x0000 must stay
        set_cfg(2'b01, 2'b00);
        pulse(1'b0, 1'b1, 16'h0000, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R1 len reset is zero", ptr0_o, 16'h0000);
        set_cfg(2'b00, 2'b00);
    endtask

    task automatic t_load();
        pulse(1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b0);
        check("R2 load ptr1", ptr1_o, 16'hBEEF);
        pulse(1'b0, 1'b1, 16'h1234, 1'b1, 1'b1);
        check("R2 load beats step", ptr0_o, 16'h1234);
        check("R2 other ptr untouched", ptr1_o, 16'hBEEF);
    endtask

    task automatic t_inc_dir();
        set_cfg(2'b00, 2'b11);
        pulse(1'b0, 1'b1, 16'h0050, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R3 inc ignores down dir", ptr0_o, 16'h0051);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b1);
        check("R3 inc beats update", ptr0_o, 16'h0052);
    endtask

    task automatic t_auto_dir();
        set_cfg(2'b00, 2'b10);
        pulse(1'b0, 1'b1, 16'h0400, 1'b0, 1'b0);
        pulse(1'b1, 1'b1, 16'h0400, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R4 update up", ptr0_o, 16'h0401);
        pulse(1'b1, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R4 update down", ptr1_o, 16'h03FF);
    endtask

    task automatic t_modulo();
        set_cfg(2'b00, 2'b10);
        pulse(1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R5 FFFF+1", ptr0_o, 16'h0000);
        pulse(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R5 0000-1", ptr1_o, 16'hFFFF);
    endtask

    task automatic t_wrap_up();
        set_len(8'h1F);
        set_cfg(2'b11, 2'b00);
        pulse(1'b0, 1'b1, 16'h001F, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R6 end A wraps", ptr0_o, 16'h0000);
        pulse(1'b1, 1'b1, 16'h011F, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R6 end B wraps", ptr1_o, 16'h0100);
    endtask

    task automatic t_wrap_down();
        set_cfg(2'b11, 2'b11);
        pulse(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R7 start A underflows", ptr1_o, 16'h001F);
        pulse(1'b0, 1'b1, 16'h0100, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R7 start B underflows", ptr0_o, 16'h011F);
    endtask

    task automatic t_linear();
        set_cfg(2'b11, 2'b01);
        pulse(1'b0, 1'b1, 16'h0020, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R8 gap down", ptr0_o, 16'h001F);
        pulse(1'b1, 1'b1, 16'h00FF, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R8 gap up to B", ptr1_o, 16'h0100);
        pulse(1'b1, 1'b1, 16'h01FF, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R8 above B", ptr1_o, 16'h0200);
        pulse(1'b0, 1'b1, 16'h0010, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R8 inside A", ptr0_o, 16'h000F);
    endtask

    task automatic t_len_zero();
        set_len(8'h00);
        set_cfg(2'b11, 2'b10);
        pulse(1'b0, 1'b1, 16'h0000, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R9 single entry A up", ptr0_o, 16'h0000);
        pulse(1'b1, 1'b1, 16'h0100, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 16'h0, 1'b0, 1'b1);
        check("R9 single entry B down", ptr1_o, 16'h0100);
    endtask

    task automatic t_indep();
        set_len(8'h1F);
        set_cfg(2'b10, 2'b00);
        pulse(1'b0, 1'b1, 16'h001F, 1'b0, 1'b0);
        pulse(1'b1, 1'b1, 16'h001F, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R10 ptr0 linear", ptr0_o, 16'h0020);
        pulse(1'b1, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R10 ptr1 in buffer A", ptr1_o, 16'h0000);
    endtask

    task automatic t_cfg_timing();
        // length write and step in same cycle: step uses old length 0x1F
        pulse(1'b1, 1'b1, 16'h001F, 1'b0, 1'b0);
        len_we_i = 1'b1;
        len_i    = 8'h3F;
        pulse(1'b1, 1'b0, 16'h0, 1'b1, 1'b0);
        len_we_i = 1'b0;
        check("R11 old len in write cycle", ptr1_o, 16'h0000);
        pulse(1'b1, 1'b1, 16'h001F, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R11 new len later", ptr1_o, 16'h0020);
        // enable write with step in same cycle: ptr0 still linear
        pulse(1'b0, 1'b1, 16'h003F, 1'b0, 1'b0);
        cfg_we_i   = 1'b1;
        cfg_circ_i = 2'b11;
        cfg_dir_i  = 2'b00;
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        cfg_we_i = 1'b0;
        check("R11 old enable in write cycle", ptr0_o, 16'h0040);
        pulse(1'b0, 1'b1, 16'h003F, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check("R11 new enable later", ptr0_o, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_inc_dir();
        t_auto_dir();
        t_modulo();
        t_wrap_up();
        t_wrap_down();
        t_linear();
        t_len_zero();
        t_indep();
        t_cfg_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule